// File: doc/BRIEF.md
# D-PHY test port sequencer

This block drives the serial configuration port of a D-PHY: an enable line, a test clock, an 8-bit write bus towards the PHY and an 8-bit read bus back from it. A host request names a PHY register. It can carry a byte to write, and it says whether a data phase follows the register selection. The block plays out each step of the exchange on its own registered output. It waits a fixed number of clock cycles between steps and captures the byte the PHY presents while the test clock is high.

A second request type takes a high-speed lane rate in MHz instead of a register code. The block turns that rate into the PHY's frequency-range byte with a built-in band lookup. It writes that byte to the range register and then issues the closing register selection with no data phase, all as one host request. The host starts work with a start pulse, sees `busy` while the exchange runs, and gets a one-cycle `done` when it ends.

Top module: `dphy_tport_seq`

## Requirements
- R1: While reset is asserted and after it, before any request: `tp_en`, `tp_clk`, `busy` and `done` are low, and `tp_din` and `rd_byte` are 0x00.
- R2: The register-select phase runs in five steps: `tp_en` rises, then `tp_clk` rises, then `tp_din` takes the register code, then `tp_clk` falls, then `tp_en` falls. The PHY takes the code at the falling test clock while enable is high.
- R3: If a data phase is requested, it follows the select phase in four steps with `tp_en` low throughout: `tp_din` takes the write byte, then `tp_clk` rises, then `tp_dout` is sampled while the test clock is high, then `tp_clk` falls.
- R4: Consecutive steps are exactly GAP_CYC clock cycles apart, so changes on `tp_en` and `tp_clk` are never closer than GAP_CYC cycles. `tp_din` never changes in the same cycle as `tp_en` or `tp_clk`.
- R5: `done` is high for exactly one cycle, GAP_CYC cycles after the last step of the request. `busy` falls in that same cycle.
- R6: A start request seen while `busy` is high is ignored. This includes the cycle in which `done` is being produced. A start one cycle later is accepted.
- R7: `rd_byte` is cleared to 0x00 when a start is accepted. It takes the byte sampled in a data phase and holds it until the next accepted start.
- R8: With `req_rate_mode` high, the request writes the range byte to register code 0x44 (select phase plus data phase). GAP_CYC cycles later it issues a select phase with code 0x00 and no data phase. `req_code`, `req_wdata` and `req_has_data` are ignored in this mode.
- R9: The range byte is the band value shifted left by one bit. Rates of 80 and 89 MHz give byte 0x00. 90 and 99 give 0x20. 100 gives 0x40. 110 and 129 give 0x02. 300 gives 0x0A. 1450 and 1499 give 0x78.
- R10: A rate below 80 MHz or above 1499 MHz gives range byte 0x00.
- R11: An accepted start raises `busy` and `tp_en` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start request, acted on when idle |
| req_rate_mode | input | 1 | 1: program the frequency range from `req_rate_mhz` |
| req_code | input | 8 | PHY register code for a plain request |
| req_wdata | input | 8 | Byte written in the data phase of a plain request |
| req_has_data | input | 1 | Plain request carries a data phase |
| req_rate_mhz | input | RATE_W | Lane bit rate in MHz for rate mode |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_byte | output | 8 | Byte sampled from the PHY in the last data phase |
| tp_en | output | 1 | Test port enable |
| tp_clk | output | 1 | Test port clock |
| tp_din | output | 8 | Byte driven to the PHY |
| tp_dout | input | 8 | Byte presented by the PHY |

## Verification
The completion of one request and the arrival of the next start can fall in the same cycle. This is the cycle in which the trailing gap expires, `done` is raised and `busy` is still registered high. The bench counts cycles from the accepted start and raises `req_start` exactly for that edge. It expects `done` high and `busy` low with no new enable rise. It then keeps the start high one cycle longer and expects a clean new request with its own register code and read-back byte. A scoreboard matches every observed port exchange, including its step order and spacing, against the queued expectation.

// File: rtl/dphy_tport_pkg.sv
`timescale 1ns/1ps
package dphy_tport_pkg;

    // Width of the test port byte buses.
    localparam int TP_W = 8;

    // Register selected for the frequency-range write, then the closing code.
    localparam logic [TP_W-1:0] RANGE_REG_CODE = 8'h44;
    localparam logic [TP_W-1:0] CLOSE_CODE     = 8'h00;

    // Last step applied to the port lines.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_HI,
        ST_CK_HI,
        ST_DIN_CODE,
        ST_CK_LO,
        ST_EN_LO,
        ST_DIN_DATA,
        ST_DCK_HI,
        ST_SAMPLE,
        ST_DCK_LO
    } step_e;

    typedef struct packed {
        step_e           step;
        logic            rate_m;
        logic            second;
        logic            has_data;
        logic [TP_W-1:0] code;
        logic [TP_W-1:0] wdata;
        logic            busy;
        logic            done;
        logic            en;
        logic            tclk;
        logic [TP_W-1:0] din;
        logic [TP_W-1:0] rd;
    } seq_s;

endpackage

// File: rtl/dphy_rate_band.sv
`timescale 1ns/1ps
module dphy_rate_band
    import dphy_tport_pkg::*;
#(
    parameter int RATE_W = 11
) (
    input  logic [RATE_W-1:0] rate_mhz,
    output logic [TP_W-1:0]   range_byte
);

    localparam int BAND_W = TP_W - 2;

    logic [31:0]       rate_w;
    logic [BAND_W-1:0] band;

    assign rate_w = 32'(rate_mhz);

    // Stepped bands; anything outside 80..1499 MHz falls to band zero.
    always_comb begin
        case (rate_w) inside
            [80:89]:     band = 6'h00;
            [90:99]:     band = 6'h10;
            [100:109]:   band = 6'h20;
            [110:129]:   band = 6'h01;
            [130:139]:   band = 6'h11;
            [140:149]:   band = 6'h21;
            [150:169]:   band = 6'h02;
            [170:179]:   band = 6'h12;
            [180:199]:   band = 6'h22;
            [200:219]:   band = 6'h03;
            [220:239]:   band = 6'h13;
            [240:249]:   band = 6'h23;
            [250:269]:   band = 6'h04;
            [270:299]:   band = 6'h14;
            [300:329]:   band = 6'h05;
            [330:359]:   band = 6'h15;
            [360:399]:   band = 6'h25;
            [400:449]:   band = 6'h06;
            [450:499]:   band = 6'h16;
            [500:549]:   band = 6'h07;
            [550:599]:   band = 6'h17;
            [600:649]:   band = 6'h08;
            [650:699]:   band = 6'h18;
            [700:749]:   band = 6'h09;
            [750:799]:   band = 6'h19;
            [800:849]:   band = 6'h29;
            [850:899]:   band = 6'h39;
            [900:949]:   band = 6'h0a;
            [950:999]:   band = 6'h1a;
            [1000:1049]: band = 6'h2a;
            [1050:1099]: band = 6'h3a;
            [1100:1149]: band = 6'h0b;
            [1150:1199]: band = 6'h1b;
            [1200:1249]: band = 6'h2b;
            [1250:1299]: band = 6'h3b;
            [1300:1349]: band = 6'h0c;
            [1350:1399]: band = 6'h1c;
            [1400:1449]: band = 6'h2c;
            [1450:1499]: band = 6'h3c;
            default:     band = 6'h00;
        endcase
    end

    // The PHY expects the band one bit up from the byte's LSB.
    assign range_byte = {1'b0, band, 1'b0};

endmodule

// File: rtl/dphy_gap_timer.sv
`timescale 1ns/1ps
module dphy_gap_timer #(
    parameter int GAP_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);

    localparam int CW = $clog2(GAP_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = CW'(GAP_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // Fires GAP_CYC cycles after the load that started the count.
    assign expire = (cnt_q == CW'(1));

endmodule

// File: rtl/dphy_tport_fsm.sv
`timescale 1ns/1ps
module dphy_tport_fsm
    import dphy_tport_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            rate_mode,
    input  logic [TP_W-1:0] code,
    input  logic [TP_W-1:0] wdata,
    input  logic            has_data,
    input  logic [TP_W-1:0] range_byte,
    input  logic            expire,
    input  logic [TP_W-1:0] tp_dout,
    output logic            load,
    output logic            busy,
    output logic            done,
    output logic            tp_en,
    output logic            tp_clk,
    output logic [TP_W-1:0] tp_din,
    output logic [TP_W-1:0] rd_byte
);

    seq_s s_d, s_q;
    logic txn_end;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        load     = 1'b0;
        txn_end  = 1'b0;
        if (s_q.step == ST_IDLE) begin
            if (start) begin
                s_d.step     = ST_EN_HI;
                s_d.en       = 1'b1;
                s_d.busy     = 1'b1;
                s_d.second   = 1'b0;
                s_d.rate_m   = rate_mode;
                s_d.has_data = rate_mode ? 1'b1 : has_data;
                s_d.code     = rate_mode ? RANGE_REG_CODE : code;
                s_d.wdata    = rate_mode ? range_byte : wdata;
                s_d.rd       = '0;
                load         = 1'b1;
            end
        end else if (expire) begin
            load = 1'b1;
            case (s_q.step)
                ST_EN_HI: begin
                    s_d.step = ST_CK_HI;
                    s_d.tclk = 1'b1;
                end
                ST_CK_HI: begin
                    s_d.step = ST_DIN_CODE;
                    s_d.din  = s_q.code;
                end
                ST_DIN_CODE: begin
                    s_d.step = ST_CK_LO;
                    s_d.tclk = 1'b0;
                end
                ST_CK_LO: begin
                    s_d.step = ST_EN_LO;
                    s_d.en   = 1'b0;
                end
                ST_EN_LO: begin
                    if (s_q.has_data) begin
                        s_d.step = ST_DIN_DATA;
                        s_d.din  = s_q.wdata;
                    end else begin
                        txn_end = 1'b1;
                    end
                end
                ST_DIN_DATA: begin
                    s_d.step = ST_DCK_HI;
                    s_d.tclk = 1'b1;
                end
                ST_DCK_HI: begin
                    s_d.step = ST_SAMPLE;
                    s_d.rd   = tp_dout;
                end
                ST_SAMPLE: begin
                    s_d.step = ST_DCK_LO;
                    s_d.tclk = 1'b0;
                end
                ST_DCK_LO: begin
                    txn_end = 1'b1;
                end
                default: begin
                    s_d.step = ST_IDLE;
                end
            endcase
            if (txn_end) begin
                if (s_q.rate_m && !s_q.second) begin
                    // Closing selection after the range write.
                    s_d.second   = 1'b1;
                    s_d.code     = CLOSE_CODE;
                    s_d.has_data = 1'b0;
                    s_d.step     = ST_EN_HI;
                    s_d.en       = 1'b1;
                end else begin
                    s_d.step = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                    load     = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign tp_en   = s_q.en;
    assign tp_clk  = s_q.tclk;
    assign tp_din  = s_q.din;
    assign rd_byte = s_q.rd;

endmodule

// File: rtl/dphy_tport_seq.sv
`timescale 1ns/1ps
module dphy_tport_seq
    import dphy_tport_pkg::*;
#(
    parameter int GAP_CYC = 200,
    parameter int RATE_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_rate_mode,
    input  logic [7:0]        req_code,
    input  logic [7:0]        req_wdata,
    input  logic              req_has_data,
    input  logic [RATE_W-1:0] req_rate_mhz,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_byte,
    output logic              tp_en,
    output logic              tp_clk,
    output logic [7:0]        tp_din,
    input  logic [7:0]        tp_dout
);

    logic [TP_W-1:0] range_byte;
    logic            load;
    logic            expire;

    dphy_rate_band #(
        .RATE_W(RATE_W)
    ) u_band (
        .rate_mhz  (req_rate_mhz),
        .range_byte(range_byte)
    );

    dphy_gap_timer #(
        .GAP_CYC(GAP_CYC)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .expire(expire)
    );

    dphy_tport_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (req_start),
        .rate_mode (req_rate_mode),
        .code      (req_code),
        .wdata     (req_wdata),
        .has_data  (req_has_data),
        .range_byte(range_byte),
        .expire    (expire),
        .tp_dout   (tp_dout),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .tp_en     (tp_en),
        .tp_clk    (tp_clk),
        .tp_din    (tp_din),
        .rd_byte   (rd_byte)
    );

endmodule

// File: rtl/dphy_tport_chk.sv
`timescale 1ns/1ps
module dphy_tport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       busy,
    input logic       done,
    input logic       tp_en,
    input logic       tp_clk,
    input logic [7:0] tp_din,
    input logic [7:0] rd_byte
);

    // R11
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy) |=> (busy && tp_en));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    din_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tp_din) |-> ($stable(tp_clk) && $stable(tp_en)));

    // R2
    en_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tp_en) |-> !tp_clk);

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_start) |=> $stable(rd_byte));

    // R1
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tp_en && !tp_clk));

endmodule

bind dphy_tport_seq dphy_tport_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_start(req_start),
    .busy     (busy),
    .done     (done),
    .tp_en    (tp_en),
    .tp_clk   (tp_clk),
    .tp_din   (tp_din),
    .rd_byte  (rd_byte)
);

// File: tb/sim_dphy_tport_seq.sv
`timescale 1ns/1ps
module sim_dphy_tport_seq;

    localparam int G = 8;

    typedef struct {
        logic [7:0]  code;
        logic        has_data;
        logic [7:0]  data;
        logic [31:0] sig;
        logic        last;
        logic [7:0]  rd_exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_rate_mode = 1'b0;
    logic [7:0]  req_code = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_has_data = 1'b0;
    logic [10:0] req_rate_mhz = '0;
    logic        busy, done, tp_en, tp_clk;
    logic [7:0]  rd_byte, tp_din, tp_dout;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    item_t exp_q[$];
    item_t obs_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    dphy_tport_seq #(.GAP_CYC(G), .RATE_W(11)) u0 (
        .clk(clk), .rst_n(rst_n), .req_start(req_start),
        .req_rate_mode(req_rate_mode), .req_code(req_code),
        .req_wdata(req_wdata), .req_has_data(req_has_data),
        .req_rate_mhz(req_rate_mhz), .busy(busy), .done(done),
        .rd_byte(rd_byte), .tp_en(tp_en), .tp_clk(tp_clk),
        .tp_din(tp_din), .tp_dout(tp_dout)
    );

    // Behavioural PHY register file behind the test port.
    logic [7:0] phy_reg [256];
    logic [7:0] phy_addr;

    always @(negedge tp_clk or negedge rst_n) begin
        if (!rst_n) phy_addr <= 8'h00;
        else if (tp_en) phy_addr <= tp_din;
    end

    always @(posedge tp_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) phy_reg[i] <= 8'(i) ^ 8'h5A;
        end else if (!tp_en) begin
            phy_reg[phy_addr] <= tp_din;
        end
    end

    assign tp_dout = phy_reg[phy_addr];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    logic  pen = 1'b0, pclk = 1'b0, pdone = 1'b0;
    int    last_ev = -1;
    bit    cur_open = 0;
    item_t cur;

    task automatic score();
        item_t e, o;
        while (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            if (obs_q.size() == 0) begin
                check(0, e.req, "missing port exchange", 0, 1);
            end else begin
                o = obs_q.pop_front();
                check(o.code == e.code, e.req, "register code", o.code, e.code);
                check(o.has_data == e.has_data, e.req, "data phase present", o.has_data, e.has_data);
                if (e.has_data)
                    check(o.data == e.data, e.req, "written byte", o.data, e.data);
                check(o.sig == e.sig, e.req, "step order", o.sig, e.sig);
            end
            if (e.last) begin
                // R7 read-back byte after completion
                check(rd_byte == e.rd_exp, "R7", "rd_byte at done", rd_byte, e.rd_exp);
                break;
            end
        end
        // R6 no extra exchange from an ignored start
        check(obs_q.size() == 0, "R6", "extra exchanges", obs_q.size(), 0);
        obs_q.delete();
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (tp_en != pen || tp_clk != pclk) begin
                // R4 spacing between line changes
                if (last_ev >= 0) check(cyc - last_ev >= G, "R4", "edge spacing", cyc - last_ev, G);
                last_ev = cyc;
            end
            if (tp_en && !pen) begin
                if (cur_open) obs_q.push_back(cur);
                cur = '{code: 8'h00, has_data: 1'b0, data: 8'h00, sig: 32'h1,
                        last: 1'b0, rd_exp: 8'h00, req: ""};
                cur_open = 1;
            end
            if (tp_clk && !pclk) begin
                cur.sig = (cur.sig << 4) | 32'h3;
                if (!tp_en) begin
                    cur.has_data = 1'b1;
                    cur.data = tp_din;
                end
            end
            if (!tp_clk && pclk) begin
                cur.sig = (cur.sig << 4) | 32'h4;
                if (tp_en) cur.code = tp_din;
            end
            if (!tp_en && pen) cur.sig = (cur.sig << 4) | 32'h2;
            if (done) begin
                // R5 done GAP cycles after the last step
                check(cyc - last_ev == G, "R5", "done delay", cyc - last_ev, G);
                if (cur_open) obs_q.push_back(cur);
                cur_open = 0;
                score();
            end
            if (done && pdone) check(0, "R5", "done longer than one cycle", 2, 1);
            pen = tp_en;
            pclk = tp_clk;
            pdone = done;
        end
    end

    // ---------------- driver ----------------
    task automatic expect_plain(logic [7:0] code, logic hasd, logic [7:0] data);
        item_t e;
        e.code = code; e.has_data = hasd; e.data = data;
        e.sig = hasd ? 32'h134234 : 32'h1342;
        e.last = 1'b1; e.rd_exp = hasd ? data : 8'h00;
        e.req = hasd ? "R3" : "R2";
        exp_q.push_back(e);
    endtask

    task automatic expect_rate(logic [7:0] rbyte, string req);
        item_t e;
        e.code = 8'h44; e.has_data = 1'b1; e.data = rbyte; e.sig = 32'h134234;
        e.last = 1'b0; e.rd_exp = 8'h00; e.req = req;
        exp_q.push_back(e);
        e.code = 8'h00; e.has_data = 1'b0; e.data = 8'h00; e.sig = 32'h1342;
        e.last = 1'b1; e.rd_exp = rbyte; e.req = "R8";
        exp_q.push_back(e);
    endtask

    // Called just after a negedge; leaves start low one negedge later.
    task automatic issue(logic rm, logic [7:0] code, logic [7:0] wd, logic hasd, logic [10:0] rate);
        req_rate_mode = rm; req_code = code; req_wdata = wd;
        req_has_data = hasd; req_rate_mhz = rate; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        // R11 accepted start shows on the next edge
        check(busy && tp_en, "R11", "busy/en after start", {busy, tp_en}, 2'b11);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic run_rate(logic [10:0] rate, logic [7:0] rbyte, string req);
        expect_rate(rbyte, req);
        issue(1'b1, 8'h99, 8'hEE, 1'b0, rate);
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check(!tp_en && !tp_clk && !busy && !done, "R1", "control lines in reset",
              {tp_en, tp_clk, busy, done}, 0);
        check(tp_din == 8'h00 && rd_byte == 8'h00, "R1", "byte outputs in reset",
              {tp_din, rd_byte}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !tp_en, "R1", "idle after reset", {busy, tp_en}, 0);

        // R2 select phase only
        expect_plain(8'h3B, 1'b0, 8'h00);
        issue(1'b0, 8'h3B, 8'h00, 1'b0, 11'd0);
        wait_done();

        // R3 select plus data phase, read-back of written byte
        expect_plain(8'h12, 1'b1, 8'hC7);
        issue(1'b0, 8'h12, 8'hC7, 1'b1, 11'd0);
        wait_done();
        repeat (3 * G) @(negedge clk);
        check(rd_byte == 8'hC7, "R7", "rd_byte held while idle", rd_byte, 8'hC7);

        // R6 start during busy ignored; R7 clear on accepted start
        expect_plain(8'h20, 1'b1, 8'h33);
        issue(1'b0, 8'h20, 8'h33, 1'b1, 11'd0);
        check(rd_byte == 8'h00, "R7", "rd_byte cleared on start", rd_byte, 8'h00);
        repeat (3 * G) @(negedge clk);
        req_code = 8'h77; req_has_data = 1'b0; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done();
        repeat (4 * G) @(negedge clk);
        check(!busy && !tp_en, "R6", "no request after ignored start", {busy, tp_en}, 0);

        // R6 start in the completion cycle is ignored, next cycle accepted
        expect_plain(8'h2D, 1'b0, 8'h00);
        issue(1'b0, 8'h2D, 8'h00, 1'b0, 11'd0);
        repeat (5 * G - 1) @(negedge clk);
        req_code = 8'h5E; req_wdata = 8'h81; req_has_data = 1'b1; req_start = 1'b1;
        @(negedge clk);
        check(done && !busy, "R6", "done with colliding start", {done, busy}, 2'b10);
        expect_plain(8'h5E, 1'b1, 8'h81);
        @(negedge clk);
        req_start = 1'b0;
        check(busy && tp_en, "R6", "start one cycle after done accepted", {busy, tp_en}, 2'b11);
        wait_done();

        // R8 R9 range programming by band
        run_rate(11'd80,   8'h00, "R9");
        run_rate(11'd89,   8'h00, "R9");
        run_rate(11'd90,   8'h20, "R9");
        run_rate(11'd99,   8'h20, "R9");
        run_rate(11'd100,  8'h40, "R9");
        run_rate(11'd110,  8'h02, "R9");
        run_rate(11'd129,  8'h02, "R9");
        run_rate(11'd300,  8'h0A, "R9");
        run_rate(11'd1450, 8'h78, "R9");
        run_rate(11'd1499, 8'h78, "R9");
        // R10 out of range
        run_rate(11'd79,   8'h00, "R10");
        run_rate(11'd1500, 8'h00, "R10");
        run_rate(11'd2047, 8'h00, "R10");
        run_rate(11'd0,    8'h00, "R10");

        check(exp_q.size() == 0, "R8", "unconsumed expectations", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule